// File: doc/BRIEF.md
# Replayable FIFO with half-full status

This block is a single-clock first-in/first-out buffer with nine-bit words and a depth set by a parameter (512, 1024, 2048, 4096 or 8192 words). Words go in through a write strobe and come out through a read strobe. There is no address input: a write pointer and a read pointer each step through the storage as a ring. Both strobes may be active in the same clock, and each is acted on when the flags allow it. The ninth bit has no special meaning inside the block, so a user can carry parity or a control marker in it.

Three status outputs show how full the buffer is: empty, full, and a half-full flag that is set when more than half the depth is in use. An active-low replay input moves the read pointer back to where it was after reset. The write pointer is not touched, so every word written since reset can be read out again from the first one. This works for link-level resends as long as the total number of words written since reset stays below the depth. A synchronous active-low reset clears both pointers, the flags and the read-data register.

Top module: `retx_fifo`

## Requirements
- R1: While `rstN` is low at a rising clock edge, both pointers clear. After the edge `emptyFlag` is 1, `fullFlag` and `halfFlag` are 0, and `rdData` is 0.
- R2: Words come out in the order they were written, with all nine bits intact.
- R3: A write strobe while `fullFlag` is 1 is ignored. No stored word is overwritten and the occupancy does not change.
- R4: A read strobe while `emptyFlag` is 1 is ignored. `rdData` keeps its previous value and the occupancy does not change.
- R5: A write and a read in the same cycle are both serviced when neither flag blocks them, and the occupancy stays the same. On an empty buffer only the write takes effect. On a full buffer only the read takes effect.
- R6: `emptyFlag` is 1 exactly when the occupancy is zero.
- R7: `fullFlag` is 1 exactly when the occupancy equals the depth.
- R8: `halfFlag` is 1 exactly when the occupancy is greater than half the depth.
- R9: When `rtN` is low at a rising edge, the read pointer goes back to its post-reset position. A read strobe in the same cycle is ignored and a write in the same cycle still takes effect. Later reads restart from the first word written since reset. This holds only while fewer than depth words have been written since reset.
- R10: An accepted read updates `rdData` at the same clock edge. The flags reflect every pointer change from that edge onward. `rdData` holds its value in every cycle with no accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 9 | Word to store |
| rdEn | input | 1 | Read strobe |
| rtN | input | 1 | Replay request, active low |
| rdData | output | 9 | Last word read out |
| emptyFlag | output | 1 | No words stored |
| fullFlag | output | 1 | Depth words stored |
| halfFlag | output | 1 | More than half the depth stored |

## Verification
The bench fills the buffer completely and then drains it, one word per cycle. At every step it checks each flag against the count it keeps itself, so both thresholds and both edges of the half-full flag are hit. It also drives blocked writes at full, blocked reads at empty, and combined read/write strobes at empty, at full and at a mid-level count. These patterns separate a flag that gates too much from one that gates too little. The replay runs pair the rewind with a read strobe and a write strobe in the same cycle, and repeat it on an emptied buffer. This shows that only the read side moves and that the data order restarts from the first word.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;
  // Per-cycle actions the control side grants to the storage side
  typedef struct packed {
    logic wrGo;
    logic rdGo;
  } fifoStrobe_t;
endpackage

// File: rtl/retx_fifo_ctrl.sv
module retx_fifo_ctrl
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic                      rtN,
  output fifoStrobe_t               strobe,
  output logic [$clog2(DEPTH)-1:0]  wrAddr,
  output logic [$clog2(DEPTH)-1:0]  rdAddr,
  output logic                      emptyFlag,
  output logic                      fullFlag,
  output logic                      halfFlag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LEVEL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LEVEL = PW'(DEPTH / 2);

  // One extra bit on each pointer tells full apart from empty
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] occupancy;
  logic          rewind;

  assign occupancy = wrPtr - rdPtr;
  assign rewind    = !rtN;

  assign emptyFlag = (occupancy == '0);
  assign fullFlag  = (occupancy == FULL_LEVEL);
  assign halfFlag  = (occupancy > HALF_LEVEL);

  assign strobe.wrGo = wrEn && !fullFlag;
  assign strobe.rdGo = rdEn && !emptyFlag && !rewind;

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobe.wrGo) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
    end else if (rewind) begin
      rdPtr <= '0;
    end else if (strobe.rdGo) begin
      rdPtr <= rdPtr + 1'b1;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && wrEn) |=> (wrPtr == $past(wrPtr)));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && rdEn && rtN) |=> $stable(rdPtr));

  // R5
  both_sides_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && rtN && !emptyFlag && !fullFlag) |=> $stable(occupancy));

  // R9
  rewind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rtN) |=> (rdPtr == '0));

  // R9
  rewind_wr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rtN && !wrEn) |=> $stable(wrPtr));
endmodule

// File: rtl/retx_fifo_data.sv
module retx_fifo_data
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fifoStrobe_t               strobe,
  input  logic [$clog2(DEPTH)-1:0]  wrAddr,
  input  logic [$clog2(DEPTH)-1:0]  rdAddr,
  input  logic [WIDTH-1:0]          wrData,
  output logic [WIDTH-1:0]          rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrGo) begin
      store[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdGo) begin
      rdData <= store[rdAddr];
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdGo) |=> $stable(rdData));
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo
  import retx_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             rtN,
  output logic [WIDTH-1:0] rdData,
  output logic             emptyFlag,
  output logic             fullFlag,
  output logic             halfFlag
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  retx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .rtN       (rtN),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr),
    .emptyFlag (emptyFlag),
    .fullFlag  (fullFlag),
    .halfFlag  (halfFlag)
  );

  retx_fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

  // R6
  empty_after_reset_chk: assert property (@(posedge clk)
    (!rstN) |=> (emptyFlag && !fullFlag && !halfFlag));
endmodule

// File: tb/retx_fifo_tb.sv
module retx_fifo_tb;
  localparam int D = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic       rtN = 1'b1;
  logic [8:0] rdData;
  logic       emptyFlag, fullFlag, halfFlag;

  always #10 clk = ~clk;

  retx_fifo #(.DEPTH(D), .WIDTH(9)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rtN(rtN), .rdData(rdData), .emptyFlag(emptyFlag), .fullFlag(fullFlag),
    .halfFlag(halfFlag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [8:0] hist [D];
  int         wrIdx = 0;
  int         rdIdx = 0;
  logic [8:0] lastData = '0;

  function automatic logic [8:0] pat(int i, int s);
    return 9'((i * 37) + (s * 101) + 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    int cnt = wrIdx - rdIdx;
    chk("R6 empty", int'(emptyFlag), int'(cnt == 0));
    chk("R7 full", int'(fullFlag), int'(cnt == D));
    chk("R8 half", int'(halfFlag), int'(cnt > D / 2));
    chk(tag, int'(rdData), int'(lastData));
  endtask

  // Drive at a falling edge, update the model at the rising edge, check at the next falling edge
  task automatic step(bit wr, logic [8:0] wd, bit rd, bit rt, string tag);
    int cnt;
    wrEn = wr; wrData = wd; rdEn = rd; rtN = !rt;
    @(posedge clk);
    cnt = wrIdx - rdIdx;
    if (rt) rdIdx = 0;
    else if (rd && cnt > 0) begin
      lastData = hist[rdIdx % D];
      rdIdx++;
    end
    if (wr && cnt < D) begin
      hist[wrIdx % D] = wd;
      wrIdx++;
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; rtN = 1'b1;
    checkState(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    wrIdx = 0; rdIdx = 0; lastData = '0;
    chk("R1 empty", int'(emptyFlag), 1);
    chk("R1 full", int'(fullFlag), 0);
    chk("R1 half", int'(halfFlag), 0);
    chk("R1 rdData", int'(rdData), 0);
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R2 R7 R8: fill to the top, flags checked at every level
    for (int i = 0; i < D; i++) step(1'b1, pat(i, 0), 1'b0, 1'b0, "R2 fill");
    // R3: writes at full are dropped
    for (int i = 0; i < 3; i++) step(1'b1, 9'h1AA, 1'b0, 1'b0, "R3 blocked write");
    // R5: read and write together at full, only the read happens
    step(1'b1, 9'h155, 1'b1, 1'b0, "R5 full both");
    // R2 R10: drain, order and flag edges checked
    while (wrIdx != rdIdx) step(1'b0, '0, 1'b1, 1'b0, "R2 drain");
    // R4: reads at empty leave rdData and flags alone
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0, "R4 blocked read");
    // R5: both at empty, only the write happens
    step(1'b1, pat(0, 1), 1'b1, 1'b0, "R5 empty both");
    step(1'b1, pat(1, 1), 1'b0, 1'b0, "R2 refill");
    step(1'b1, pat(2, 1), 1'b0, 1'b0, "R2 refill");
    // R5: steady traffic at mid level keeps the count
    for (int i = 3; i < 40; i++) step(1'b1, pat(i, 1), 1'b1, 1'b0, "R5 mid both");
    // R1: reset with data present
    doReset();

    // R9: replay after partial read, with read and write strobes in the rewind cycle
    for (int i = 0; i < 10; i++) step(1'b1, pat(i, 2), 1'b0, 1'b0, "R2 load");
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b0, "R2 partial read");
    step(1'b1, pat(10, 2), 1'b1, 1'b1, "R9 rewind hold");
    chk("R9 rewound not empty", int'(emptyFlag), 0);
    for (int i = 0; i < 11; i++) begin
      step(1'b0, '0, 1'b1, 1'b0, "R9 replay");
      chk("R9 replay order", int'(rdData), int'(pat(i, 2)));
    end
    // R9: rewind on an emptied buffer brings all words back
    step(1'b0, '0, 1'b0, 1'b1, "R9 second rewind");
    chk("R9 refilled by rewind", int'(emptyFlag), 0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, '0, 1'b1, 1'b0, "R9 second replay");
      chk("R9 second replay order", int'(rdData), int'(pat(i, 2)));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule